// File: doc/BRIEF.md
# Three-Wire Command Port Slave

This block is the serial access port for a pair of 32-bit seconds counters. An external host raises an enable line, clocks in one command byte, and then either clocks 32 data bits out of the port or 32 bits into it. The command byte chooses one of the two counters and the transfer direction. It can also load a three-bit oscillator trim value, or ask for one or both counters to be cleared. The counters and the oscillator are outside this block. It reads their values from two input buses and acts on them through one-cycle strobes and a trim register.

The serial pins are sampled in the system clock domain through a synchronizer, and their edges are found by comparing successive samples. The data line is split into an input, an output and an output enable, so the pad can be wired as a bidirectional pin. On a read, the selected counter is captured at the end of the command byte. The captured word is shifted out, so the result stays consistent even if the counter ticks during the transfer. On a write, the 32 received bits reach the selected counter as one parallel word with a single strobe. A clear command only sets a pending request, and the clear strobe fires when the enable line falls. While the supply-valid input is low, the port does nothing.

Top module: `tw_cmd_slave`

## Requirements
- R1: After reset the trim output is 3'b011, the data output enable is low, and all load and clear strobes are low.
- R2: The command byte is sampled on rising serial-clock edges, least significant bit first. Its bits are: bit 7 selects the continuous counter, bit 6 selects the supply counter, bits 5:3 are the trim value, bit 2 requests a continuous-counter clear, bit 1 requests a supply-counter clear, and bit 0 is the direction (1 = read, 0 = write).
- R3: With exactly one select bit set and bit 0 = 1, the selected counter is captured at the 8th rising edge. Its 32 bits are then driven LSB first, one per falling edge, starting with the falling edge right after the 8th rising edge.
- R4: During a read, the data output enable is high only while the serial clock is low. It drops after every rising edge.
- R5: With exactly one select bit set and bit 0 = 0, 32 bits are sampled LSB first on rising edges. The 32nd rising edge produces exactly one load strobe for the selected counter, with the assembled word on the load data bus.
- R6: With both select bits set, bits 5:3 are loaded into the trim register at the 8th rising edge. Every further clock in that transfer is ignored: no drive and no load.
- R7: With neither select bit set, the command is clear-only. When the enable falls, a one-cycle clear strobe is issued for each requested counter, and both may be cleared together.
- R8: The clear bits have no effect when a select bit is set.
- R9: After the 32 data bits of a read or write, further clocks are ignored until enable falls and rises again.
- R10: When the enable falls, the transfer ends at once: the data output enable is released, and a write cut short before its 32nd bit loads nothing.
- R11: While supply-valid is low, the port does not respond. A pending clear is discarded if supply-valid drops before the enable falls.
- R12: The value shifted out on a read is the one captured at the 8th rising edge. Later changes on the counter inputs do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply-valid condition; low disables the port |
| ser_en | input | 1 | Serial transfer enable, high during a transfer |
| ser_clk | input | 1 | Serial clock |
| ser_din | input | 1 | Serial data from the pad |
| ser_dout | output | 1 | Serial data to the pad |
| ser_doe | output | 1 | Pad output enable for ser_dout |
| cont_count | input | 32 | Current continuous-counter value |
| supply_count | input | 32 | Current supply-counter value |
| load_cont | output | 1 | One-cycle load strobe for the continuous counter |
| load_supply | output | 1 | One-cycle load strobe for the supply counter |
| load_data | output | 32 | Word to load, valid with a load strobe |
| clr_cont | output | 1 | One-cycle clear strobe for the continuous counter |
| clr_supply | output | 1 | One-cycle clear strobe for the supply counter |
| trim | output | 3 | Oscillator trim register |

## Verification
A bit counter that is off by one appears within the same transfer. A read word comes out shifted or with a stray bit, or the load strobe fires one data clock early or late and carries a shifted word. A phase that is decoded wrongly shows up at the next command as a drive during a trim or clear command, a missing or extra strobe, or a wrong trim value. Pending-clear state that leaks between transfers, or survives loss of supply, appears as an unexpected clear strobe a few system clocks after the enable falls.

// File: rtl/tw_pkg.sv
// Shared types for the three-wire command port.
// Assumes the command byte layout is fixed at eight bits, MSB first in the struct.
package tw_pkg;

    localparam int TRIM_W = 3;

    // Transfer phase of the port.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_RD,
        PH_WR,
        PH_HOLD
    } tw_phase_e;

    // Action picked by the command byte.
    typedef enum logic [1:0] {
        ACT_CLEAR,
        ACT_TRIM,
        ACT_READ,
        ACT_WRITE
    } tw_act_e;

    // Command byte, bit 7 down to bit 0.
    typedef struct packed {
        logic              sel_cont;
        logic              sel_sup;
        logic [TRIM_W-1:0] trim;
        logic              clr_cont;
        logic              clr_sup;
        logic              rd;
    } tw_cmd_t;

endpackage

// File: rtl/tw_input_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes STAGES >= 2; the output is STAGES clocks behind the input.
module tw_input_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    localparam int TOT_W = WIDTH * STAGES;

    logic [TOT_W-1:0] pipe_q;

    // Shift each input through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[TOT_W-WIDTH-1:0], din};
    end

    assign dout = pipe_q[TOT_W-1 -: WIDTH];

endmodule

// File: rtl/tw_cmd_decode.sv
// Decodes a received command byte into an action, a target and clear requests.
// Assumes the byte is complete; purely combinational.
module tw_cmd_decode
    import tw_pkg::*;
(
    input  tw_cmd_t           cmd,
    output tw_act_e           act,
    output logic              tgt_cont,
    output logic              clr_cont_req,
    output logic              clr_sup_req,
    output logic [TRIM_W-1:0] trim_val
);

    // Pick the action from the two select bits and the direction flag.
    always_comb begin
        if (cmd.sel_cont && cmd.sel_sup)       act = ACT_TRIM;
        else if (!cmd.sel_cont && !cmd.sel_sup) act = ACT_CLEAR;
        else if (cmd.rd)                       act = ACT_READ;
        else                                   act = ACT_WRITE;
    end

    // Clear requests count only in a clear-only command.
    always_comb begin
        clr_cont_req = !cmd.sel_cont && !cmd.sel_sup && cmd.clr_cont;
        clr_sup_req  = !cmd.sel_cont && !cmd.sel_sup && cmd.clr_sup;
    end

    assign tgt_cont = cmd.sel_cont;
    assign trim_val = cmd.trim;

endmodule

// File: rtl/tw_cmd_slave.sv
// Three-wire serial slave: an 8-bit command, then 32 data bits in or out, LSB first.
// Assumes the serial pins change slowly relative to clk: each serial clock
// half-period lasts at least SYNC_STAGES + 2 system clocks.
module tw_cmd_slave
    import tw_pkg::*;
#(
    parameter int                DATA_W      = 32,
    parameter int                SYNC_STAGES = 2,
    parameter logic [TRIM_W-1:0] TRIM_RST    = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              ser_en,
    input  logic              ser_clk,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              ser_doe,
    input  logic [DATA_W-1:0] cont_count,
    input  logic [DATA_W-1:0] supply_count,
    output logic              load_cont,
    output logic              load_supply,
    output logic [DATA_W-1:0] load_data,
    output logic              clr_cont,
    output logic              clr_supply,
    output logic [TRIM_W-1:0] trim
);

    localparam int CMD_W = $bits(tw_cmd_t);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] DATA_DONE = CNT_W'(DATA_W);

    logic sup_s, en_s, sclk_s, din_s;
    logic en_eff, en_eff_q, sclk_q, sclk_rise, sclk_fall;

    tw_phase_e         phase;
    logic [CNT_W-1:0]  bitcnt;
    logic [CMD_W-1:0]  cmd_sr;
    logic [DATA_W-1:0] data_sr;
    logic              tgt_cont_q, pend_cc, pend_cs;
    logic [TRIM_W-1:0] trim_q;
    logic              dout_q, doe_q, ld_cont_q, ld_sup_q, clr_cont_q, clr_sup_q;

    tw_cmd_t           cmd_next;
    tw_act_e           dec_act;
    logic              dec_tgt, dec_cc, dec_cs;
    logic [TRIM_W-1:0] dec_trim;
    logic [DATA_W-1:0] wr_next;

    tw_input_sync #(
        .WIDTH  (4),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({supply_ok, ser_en, ser_clk, ser_din}),
        .dout  ({sup_s, en_s, sclk_s, din_s})
    );

    assign en_eff    = en_s && sup_s;
    assign sclk_rise = sclk_s && !sclk_q;
    assign sclk_fall = !sclk_s && sclk_q;
    assign cmd_next  = tw_cmd_t'({din_s, cmd_sr[CMD_W-1:1]});
    assign wr_next   = {din_s, data_sr[DATA_W-1:1]};

    tw_cmd_decode u_dec (
        .cmd          (cmd_next),
        .act          (dec_act),
        .tgt_cont     (dec_tgt),
        .clr_cont_req (dec_cc),
        .clr_sup_req  (dec_cs),
        .trim_val     (dec_trim)
    );

    // Transfer sequencer: command shift, data shift, strobes and deferred clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            bitcnt     <= '0;
            cmd_sr     <= '0;
            data_sr    <= '0;
            tgt_cont_q <= 1'b0;
            pend_cc    <= 1'b0;
            pend_cs    <= 1'b0;
            trim_q     <= TRIM_RST;
            dout_q     <= 1'b0;
            doe_q      <= 1'b0;
            ld_cont_q  <= 1'b0;
            ld_sup_q   <= 1'b0;
            clr_cont_q <= 1'b0;
            clr_sup_q  <= 1'b0;
            en_eff_q   <= 1'b0;
            sclk_q     <= 1'b0;
        end else begin
            ld_cont_q  <= 1'b0;
            ld_sup_q   <= 1'b0;
            clr_cont_q <= 1'b0;
            clr_sup_q  <= 1'b0;
            en_eff_q   <= en_eff;
            sclk_q     <= sclk_s;
            if (!en_eff) begin
                if (en_eff_q && sup_s) begin
                    clr_cont_q <= pend_cc;
                    clr_sup_q  <= pend_cs;
                end
                phase   <= PH_IDLE;
                bitcnt  <= '0;
                pend_cc <= 1'b0;
                pend_cs <= 1'b0;
                doe_q   <= 1'b0;
            end else if (!en_eff_q) begin
                phase   <= PH_CMD;
                bitcnt  <= '0;
                pend_cc <= 1'b0;
                pend_cs <= 1'b0;
            end else if (sclk_rise) begin
                doe_q <= 1'b0;
                case (phase)
                    PH_CMD: begin
                        cmd_sr <= cmd_next;
                        if (bitcnt == CMD_LAST) begin
                            bitcnt     <= '0;
                            tgt_cont_q <= dec_tgt;
                            case (dec_act)
                                ACT_TRIM: begin
                                    trim_q <= dec_trim;
                                    phase  <= PH_HOLD;
                                end
                                ACT_CLEAR: begin
                                    pend_cc <= dec_cc;
                                    pend_cs <= dec_cs;
                                    phase   <= PH_HOLD;
                                end
                                ACT_READ: begin
                                    data_sr <= dec_tgt ? cont_count : supply_count;
                                    phase   <= PH_RD;
                                end
                                default: phase <= PH_WR;
                            endcase
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    PH_WR: begin
                        data_sr <= wr_next;
                        if (bitcnt == DATA_LAST) begin
                            ld_cont_q <= tgt_cont_q;
                            ld_sup_q  <= !tgt_cont_q;
                            phase     <= PH_HOLD;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    PH_RD: begin
                        if (bitcnt == DATA_DONE) phase <= PH_HOLD;
                    end
                    default: ;
                endcase
            end else if (sclk_fall && phase == PH_RD && bitcnt != DATA_DONE) begin
                dout_q  <= data_sr[0];
                data_sr <= data_sr >> 1;
                bitcnt  <= bitcnt + 1'b1;
                doe_q   <= 1'b1;
            end
        end
    end

    assign ser_dout    = dout_q;
    assign ser_doe     = doe_q;
    assign load_cont   = ld_cont_q;
    assign load_supply = ld_sup_q;
    assign load_data   = data_sr;
    assign clr_cont    = clr_cont_q;
    assign clr_supply  = clr_sup_q;
    assign trim        = trim_q;

    // Release of the line after every rising serial edge.
    assert_rise_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> !ser_doe);

    // The line is driven only in the read phase.
    assert_drive_in_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ser_doe |-> (phase == PH_RD));

    // A write loads one counter at most.
    assert_one_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_cont, load_supply}));

    // Clears come only right after the enable has fallen.
    assert_clear_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cont || clr_supply) |-> !$past(en_eff));

    // The trim register changes only on a sampled rising serial edge.
    assert_trim_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(trim) |-> $past(sclk_rise));

    // Dropping the enable releases the line.
    assert_abort_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_eff |=> !ser_doe);

    // No drive and no load while supply is invalid.
    assert_supply_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_s |=> !(ser_doe || load_cont || load_supply));

endmodule

// File: tb/tw_cmd_slave_bench.sv
// Scoreboard bench: driver tasks queue the expected strobes, a monitor pops and compares.
module tw_cmd_slave_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, supply_ok, ser_en, ser_clk, ser_din;
    logic        ser_dout, ser_doe;
    logic [31:0] cont_count, supply_count, load_data;
    logic        load_cont, load_supply, clr_cont, clr_supply;
    logic [2:0]  trim;

    localparam int       HALF      = 8;
    localparam logic [1:0] KIND_LOAD = 2'd1;
    localparam logic [1:0] KIND_CLR  = 2'd2;

    int n_vec = 0;
    int n_bad = 0;
    logic [35:0] exp_q[$];
    logic [35:0] got_item, exp_item;

    tw_cmd_slave u_tw_cmd_slave (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .ser_en(ser_en), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_dout(ser_dout), .ser_doe(ser_doe),
        .cont_count(cont_count), .supply_count(supply_count),
        .load_cont(load_cont), .load_supply(load_supply), .load_data(load_data),
        .clr_cont(clr_cont), .clr_supply(clr_supply), .trim(trim)
    );

    task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic xfer_start();
        ser_clk = 1'b0;
        ser_en  = 1'b1;
        half_wait();
    endtask

    task automatic xfer_stop();
        ser_en = 1'b0;
        half_wait();
        ser_clk = 1'b0;
        half_wait();
    endtask

    task automatic send_bit(input logic b);
        ser_clk = 1'b0;
        ser_din = b;
        half_wait();
        ser_clk = 1'b1;
        half_wait();
    endtask

    task automatic send_cmd(input logic [7:0] c);
        for (int i = 0; i < 8; i++) send_bit(c[i]);
    endtask

    task automatic send_word(input logic [31:0] w, input int n);
        for (int i = 0; i < n; i++) send_bit(w[i]);
    endtask

    // Read n bits; flags any cycle where the drive window is wrong.
    task automatic read_bits(input int n, output logic [31:0] w, output bit bad_oe);
        w = '0;
        bad_oe = 1'b0;
        for (int i = 0; i < n; i++) begin
            ser_clk = 1'b0;
            half_wait();
            if (!ser_doe) bad_oe = 1'b1;
            w[i] = ser_dout;
            ser_clk = 1'b1;
            half_wait();
            if (ser_doe) bad_oe = 1'b1;
        end
    endtask

    // Clock without expecting any drive; reports whether the line was ever driven.
    task automatic quiet_clocks(input int n, input logic b, output bit drove);
        drove = 1'b0;
        for (int i = 0; i < n; i++) begin
            ser_clk = 1'b0;
            ser_din = b;
            half_wait();
            if (ser_doe) drove = 1'b1;
            ser_clk = 1'b1;
            half_wait();
            if (ser_doe) drove = 1'b1;
        end
    endtask

    // Monitor: every strobe must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && (load_cont || load_supply || clr_cont || clr_supply)) begin
            got_item = (load_cont || load_supply) ?
                       {KIND_LOAD, load_cont, load_supply, load_data} :
                       {KIND_CLR, clr_cont, clr_supply, 32'h0};
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8/R9/R10/R11 unexpected strobe", {4'h0, got_item}, 40'h0);
            end else begin
                exp_item = exp_q.pop_front();
                chk(got_item == exp_item, "R5/R7 strobe", {4'h0, got_item}, {4'h0, exp_item});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] w;
        bit          flag;
        rst_n = 1'b0; supply_ok = 1'b1; ser_en = 1'b0; ser_clk = 1'b0; ser_din = 1'b0;
        cont_count = 32'hA5C3_0F1E; supply_count = 32'h8000_0001;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        chk(trim == 3'b011, "R1 trim", 40'(trim), 40'h3);
        chk(!ser_doe && !load_cont && !load_supply && !clr_cont && !clr_supply,
            "R1 outputs idle", {35'h0, ser_doe, load_cont, load_supply, clr_cont, clr_supply}, 40'h0);

        // R2 R3 R12 R8: read continuous counter with clear bits set, count moves mid-read
        xfer_start();
        send_cmd(8'h87);
        cont_count = 32'h1234_5678;
        read_bits(32, w, flag);
        chk(w == 32'hA5C3_0F1E, "R2/R3/R12 read continuous word", 40'(w), 40'hA5C3_0F1E);
        chk(!flag, "R4 drive window on read", 40'(flag), 40'h0);
        // R9: extra clocks after 32 read bits
        quiet_clocks(4, 1'b1, flag);
        chk(!flag, "R9 no drive after 32 bits", 40'(flag), 40'h0);
        xfer_stop();

        // R3: read supply counter
        xfer_start();
        send_cmd(8'h41);
        read_bits(32, w, flag);
        chk(w == 32'h8000_0001, "R3 read supply word", 40'(w), 40'h8000_0001);
        chk(!flag, "R4 drive window on supply read", 40'(flag), 40'h0);
        xfer_stop();

        // R5: write continuous counter
        exp_q.push_back({KIND_LOAD, 1'b1, 1'b0, 32'hDEAD_BEEF});
        xfer_start();
        send_cmd(8'h80);
        send_word(32'hDEAD_BEEF, 32);
        xfer_stop();

        // R5 R8 R9: write supply counter with clear bits set, then extra clocks
        exp_q.push_back({KIND_LOAD, 1'b0, 1'b1, 32'h0F0F_F0F0});
        xfer_start();
        send_cmd(8'h46);
        send_word(32'h0F0F_F0F0, 32);
        quiet_clocks(8, 1'b1, flag);
        chk(!flag, "R9 no drive after write", 40'(flag), 40'h0);
        xfer_stop();

        // R6 R8: trim load with clear bits set, then 32 ignored clocks
        xfer_start();
        send_cmd(8'hEE);
        quiet_clocks(32, 1'b1, flag);
        chk(trim == 3'b101, "R6 trim loaded", 40'(trim), 40'h5);
        chk(!flag, "R6 clocks after trim ignored", 40'(flag), 40'h0);
        xfer_stop();

        // R6: trim to zero
        xfer_start();
        send_cmd(8'hC0);
        xfer_stop();
        chk(trim == 3'b000, "R6 trim zero", 40'(trim), 40'h0);

        // R7: clear both, then each alone
        exp_q.push_back({KIND_CLR, 1'b1, 1'b1, 32'h0});
        xfer_start(); send_cmd(8'h06); xfer_stop();
        exp_q.push_back({KIND_CLR, 1'b1, 1'b0, 32'h0});
        xfer_start(); send_cmd(8'h04); xfer_stop();
        exp_q.push_back({KIND_CLR, 1'b0, 1'b1, 32'h0});
        xfer_start(); send_cmd(8'h03); xfer_stop();
        chk(exp_q.size() == 0, "R7 clears issued", 40'(exp_q.size()), 40'h0);

        // R10: aborted write loads nothing
        xfer_start();
        send_cmd(8'h80);
        send_word(32'hFFFF_FFFF, 20);
        xfer_stop();

        // R10: abort a read while the line is driven
        xfer_start();
        send_cmd(8'h41);
        read_bits(10, w, flag);
        ser_clk = 1'b0;
        half_wait();
        chk(ser_doe, "R3 driving before abort", 40'(ser_doe), 40'h1);
        ser_en = 1'b0;
        repeat (5) @(negedge clk);
        chk(!ser_doe, "R10 line released on abort", 40'(ser_doe), 40'h0);
        half_wait();

        // R11: supply loss discards a pending clear
        xfer_start();
        send_cmd(8'h06);
        supply_ok = 1'b0;
        half_wait();
        xfer_stop();
        // R11: no response while supply is invalid
        xfer_start();
        send_cmd(8'h81);
        quiet_clocks(4, 1'b0, flag);
        chk(!flag, "R11 no drive without supply", 40'(flag), 40'h0);
        xfer_stop();
        supply_ok = 1'b1;
        half_wait();
        half_wait();

        chk(exp_q.size() == 0, "R5/R7 missing strobe", 40'(exp_q.size()), 40'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule